// File: doc/BRIEF.md
# ADC Scan Sequencer Controller

This block is the digital sequencer for one four-input unit of a successive-approximation analog-to-digital converter. It does not contain the converter. It drives the converter through a start/busy/data handshake: it names a channel, pulses a start, waits for the converter's busy signal to rise and then fall, and captures the 12-bit result. Results are stored in one register per channel. The designated channel (channel 0) has a second register, and successive conversions of that channel alternate between the two.

Four scan modes are supported:

- **Single:** converts one chosen channel once per start.
- **One-pass:** converts every enabled channel once, in ascending order, and then stops.
- **Continuous:** repeats the enabled set for as long as the sequencer stays enabled.
- **Two-group:** splits the enabled channels into a first and a second group. Each group has its own trigger source.

A start can come from a software strobe, from a timer pulse or from a rising edge on an external pin. Each stored result can be reduced to 10-bit or 8-bit precision by a right shift.

Top module: `adc_scan_seq`

## Requirements
- R1: `cnv_start` is a one-cycle pulse that is only raised while `cnv_busy` is low. After `cnv_busy` has risen and then fallen, the value on `cnv_data` is stored for the channel that `cnv_ch` showed, and `res_wr` pulses with that channel on `res_ch`.
- R2: In single mode (`cfg_mode` = 0), each start converts only channel `cfg_single_ch`, exactly once.
- R3: In one-pass mode (`cfg_mode` = 1), each enabled bit of `cfg_chan_mask` is converted once, lowest index first. `scan_done` pulses in the same cycle as the `res_wr` of the last channel, and no further conversion follows.
- R4: In continuous mode (`cfg_mode` = 2), the enabled set repeats in ascending order, with `scan_done` at the end of every pass. After `cfg_en` falls, at most one more result is stored and then the sequencer stops.
- R5: In two-group mode (`cfg_mode` = 3), the first group is `cfg_chan_mask & ~cfg_grpb_mask` and is started by the source in `cfg_src_a`. The second group is `cfg_chan_mask & cfg_grpb_mask` and is started by the source in `cfg_src_b`. `done_grp` is 0 or 1 with `scan_done` to name the group that finished.
- R6: If both groups are started in the same cycle, the whole first group is converted before the second, and each group gives its own `scan_done`.
- R7: Source codes are 0 = `sw_start` pulse, 1 = `tmr_trig` pulse, 2 = rising edge of `ext_pin`, and 3 = no source. In modes 0 to 2, `cfg_src_a` selects the source.
- R8: A selected trigger that arrives while the sequencer is not idle starts nothing. `trig_missed` pulses in the following cycle.
- R9: `cfg_shift` = 0 stores the raw 12-bit value, 1 stores it shifted right by 2, 2 stores it shifted right by 4, and 3 stores it unshifted.
- R10: Conversions of channel 0 alternate targets. The first after reset goes to slot 0 of `res_flat`, the next to `res_dual`, and so on.
- R11: After reset, all result registers are zero and `cnv_start`, `res_wr`, `scan_done` and `trig_missed` are low.
- R12: While `cfg_en` is low, triggers start nothing and do not raise `trig_missed`. A trigger for a scan or group whose channel set is empty is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Sequencer enable |
| cfg_mode | input | 2 | Scan mode: 0 single, 1 one-pass, 2 continuous, 3 two-group |
| cfg_chan_mask | input | NCH | Enabled channels |
| cfg_single_ch | input | CH_W | Channel used in single mode |
| cfg_grpb_mask | input | NCH | Channels assigned to the second group |
| cfg_src_a | input | 2 | Trigger source of the first group (all modes) |
| cfg_src_b | input | 2 | Trigger source of the second group |
| cfg_shift | input | 2 | Precision reduction code |
| sw_start | input | 1 | Software start strobe |
| tmr_trig | input | 1 | Timer trigger pulse |
| ext_pin | input | 1 | External trigger pin (rising edge) |
| cnv_start | output | 1 | Start pulse to the converter |
| cnv_ch | output | CH_W | Channel being converted |
| cnv_busy | input | 1 | Converter busy |
| cnv_data | input | RES_W | Converter result |
| res_flat | output | NCH*RES_W | Per-channel results, channel i at bits i*RES_W |
| res_dual | output | RES_W | Second result register of channel 0 |
| res_wr | output | 1 | A result was stored in this cycle |
| res_ch | output | CH_W | Channel of the stored result |
| scan_done | output | 1 | End of a scan or group |
| done_grp | output | 1 | Group that ended (0 first, 1 second) |
| trig_missed | output | 1 | A trigger was dropped because the sequencer was busy |

## Verification
Two start requests can fall on the same clock edge. In the first case, the timer pulse of the first group and the external-pin edge of the second group are driven together while the sequencer is idle. The bench then expects channels 0, 1, 2 and 3 in that order, with two completion pulses tagged first group and then second group. In the second case, a software start is issued while a scan is in progress. It is judged by the write count staying at the set size and by exactly one missed-trigger pulse being seen.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE  = 2'd0,
    MODE_ONEPASS = 2'd1,
    MODE_CONT    = 2'd2,
    MODE_GROUPS  = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    SRC_SW  = 2'd0,
    SRC_TMR = 2'd1,
    SRC_EXT = 2'd2,
    SRC_OFF = 2'd3
  } trig_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_WAIT  = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;

  // number of low bits dropped for a precision code
  function automatic int unsigned shift_bits(input logic [1:0] code);
    case (code)
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_start,
  input  logic       tmr_trig,
  input  logic       ext_pin,
  input  logic [1:0] src_a,
  input  logic [1:0] src_b,
  output logic       trig_a,
  output logic       trig_b
);

  logic ext_q;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) ext_q <= 1'b0;
    else        ext_q <= ext_pin;
  end

  assign ext_rise = ext_pin & ~ext_q;

  function automatic logic pick(input logic [1:0] code, input logic sw,
                                input logic tm, input logic ex);
    case (trig_src_e'(code))
      SRC_SW:  return sw;
      SRC_TMR: return tm;
      SRC_EXT: return ex;
      default: return 1'b0;
    endcase
  endfunction

  assign trig_a = pick(src_a, sw_start, tmr_trig, ext_rise);
  assign trig_b = pick(src_b, sw_start, tmr_trig, ext_rise);

endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_seq_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [1:0]      mode,
  input  logic [NCH-1:0]  chan_mask,
  input  logic [CH_W-1:0] single_ch,
  input  logic [NCH-1:0]  grpb_mask,
  input  logic            trig_a,
  input  logic            trig_b,
  input  logic            cnv_busy,
  output logic            cnv_start,
  output logic [CH_W-1:0] cnv_ch,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_ch,
  output logic            scan_done,
  output logic            done_grp,
  output logic            trig_missed,
  output logic            seq_active
);

  localparam logic [CH_W:0] NONE = (CH_W+1)'(NCH);

  // lowest set bit of m at or above index from; NONE when there is none
  function automatic logic [CH_W:0] first_at(input logic [NCH-1:0] m, input int from);
    logic [CH_W:0] r;
    r = NONE;
    for (int i = NCH-1; i >= 0; i--)
      if (i >= from && m[i]) r = (CH_W+1)'(i);
    return r;
  endfunction

  seq_state_e     st;
  logic [CH_W-1:0] cur_ch;
  logic [NCH-1:0]  run_mask;
  logic            cur_grp;
  logic            pend_b;

  scan_mode_e      mode_e;
  logic            grp_mode;
  logic [NCH-1:0]  single_oh, mask_a, mask_b;
  logic            go_a, go_b, idle, conv_end, last;
  logic [CH_W:0]   first_a, first_b, first_r, nxt;

  assign mode_e    = scan_mode_e'(mode);
  assign grp_mode  = (mode_e == MODE_GROUPS);
  assign single_oh = {{(NCH-1){1'b0}}, 1'b1} << single_ch;
  assign mask_a    = grp_mode ? (chan_mask & ~grpb_mask)
                   : (mode_e == MODE_SINGLE) ? single_oh : chan_mask;
  assign mask_b    = chan_mask & grpb_mask;
  assign go_a      = en && trig_a && (|mask_a);
  assign go_b      = en && grp_mode && trig_b && (|mask_b);
  assign idle      = (st == ST_IDLE);
  assign conv_end  = (st == ST_CONV) && !cnv_busy;
  assign first_a   = first_at(mask_a, 0);
  assign first_b   = first_at(mask_b, 0);
  assign first_r   = first_at(run_mask, 0);
  assign nxt       = first_at(run_mask, int'(cur_ch) + 1);
  assign last      = (nxt == NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cur_ch      <= '0;
      run_mask    <= '0;
      cur_grp     <= 1'b0;
      pend_b      <= 1'b0;
      scan_done   <= 1'b0;
      done_grp    <= 1'b0;
      trig_missed <= 1'b0;
    end else begin
      scan_done   <= 1'b0;
      trig_missed <= en && !idle && (trig_a || (grp_mode && trig_b));
      case (st)
        ST_IDLE: begin
          if (go_a) begin
            run_mask <= mask_a;
            cur_ch   <= first_a[CH_W-1:0];
            cur_grp  <= 1'b0;
            pend_b   <= go_b;
            st       <= ST_START;
          end else if (go_b) begin
            run_mask <= mask_b;
            cur_ch   <= first_b[CH_W-1:0];
            cur_grp  <= 1'b1;
            pend_b   <= 1'b0;
            st       <= ST_START;
          end
        end
        ST_START: st <= ST_WAIT;
        ST_WAIT:  if (cnv_busy) st <= ST_CONV;
        ST_CONV: begin
          if (!cnv_busy) begin
            if (!last) begin
              if (en) begin
                cur_ch <= nxt[CH_W-1:0];
                st     <= ST_START;
              end else begin
                pend_b <= 1'b0;
                st     <= ST_IDLE;
              end
            end else begin
              scan_done <= 1'b1;
              done_grp  <= cur_grp;
              if (mode_e == MODE_CONT && en) begin
                cur_ch <= first_r[CH_W-1:0];
                st     <= ST_START;
              end else if (pend_b && en) begin
                run_mask <= mask_b;
                cur_ch   <= first_b[CH_W-1:0];
                cur_grp  <= 1'b1;
                pend_b   <= 1'b0;
                st       <= ST_START;
              end else begin
                pend_b <= 1'b0;
                st     <= ST_IDLE;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cnv_start  = (st == ST_START);
  assign cnv_ch     = cur_ch;
  assign wr_en      = conv_end;
  assign wr_ch      = cur_ch;
  assign seq_active = !idle;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int CH_W    = 2,
  parameter int RES_W   = 12,
  parameter int DUAL_CH = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [CH_W-1:0]    wr_ch,
  input  logic [RES_W-1:0]   wr_data,
  input  logic [1:0]         shift_code,
  output logic [RES_W-1:0]   wr_val,
  output logic               dual_sel,
  output logic [NCH*RES_W-1:0] res_flat,
  output logic [RES_W-1:0]   res_dual,
  output logic               res_wr,
  output logic [CH_W-1:0]    res_ch
);

  logic dual_hit;

  assign wr_val   = wr_data >> shift_bits(shift_code);
  assign dual_hit = wr_en && (wr_ch == CH_W'(DUAL_CH));

  for (genvar g = 0; g < NCH; g++) begin : g_slot
    localparam bit IS_DUAL = (g == DUAL_CH);
    logic [RES_W-1:0] slot_q;
    logic             take;
    if (IS_DUAL) begin : g_alt
      assign take = dual_hit && !dual_sel;
    end else begin : g_plain
      assign take = wr_en && (wr_ch == CH_W'(g));
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    slot_q <= '0;
      else if (take) slot_q <= wr_val;
    end
    assign res_flat[g*RES_W +: RES_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_dual <= '0;
      dual_sel <= 1'b0;
      res_wr   <= 1'b0;
      res_ch   <= '0;
    end else begin
      res_wr <= wr_en;
      res_ch <= wr_ch;
      if (dual_hit) begin
        dual_sel <= !dual_sel;
        if (dual_sel) res_dual <= wr_val;
      end
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int NCH     = 4,
  parameter int RES_W   = 12,
  parameter int DUAL_CH = 0,
  localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic [1:0]           cfg_mode,
  input  logic [NCH-1:0]       cfg_chan_mask,
  input  logic [CH_W-1:0]      cfg_single_ch,
  input  logic [NCH-1:0]       cfg_grpb_mask,
  input  logic [1:0]           cfg_src_a,
  input  logic [1:0]           cfg_src_b,
  input  logic [1:0]           cfg_shift,
  input  logic                 sw_start,
  input  logic                 tmr_trig,
  input  logic                 ext_pin,
  output logic                 cnv_start,
  output logic [CH_W-1:0]      cnv_ch,
  input  logic                 cnv_busy,
  input  logic [RES_W-1:0]     cnv_data,
  output logic [NCH*RES_W-1:0] res_flat,
  output logic [RES_W-1:0]     res_dual,
  output logic                 res_wr,
  output logic [CH_W-1:0]      res_ch,
  output logic                 scan_done,
  output logic                 done_grp,
  output logic                 trig_missed
);

  logic            trig_a, trig_b;
  logic            wr_en, seq_active, dual_sel;
  logic [CH_W-1:0] wr_ch;
  logic [RES_W-1:0] wr_val;

  adc_trig_sel u_trig (
    .clk(clk), .rst_n(rst_n),
    .sw_start(sw_start), .tmr_trig(tmr_trig), .ext_pin(ext_pin),
    .src_a(cfg_src_a), .src_b(cfg_src_b),
    .trig_a(trig_a), .trig_b(trig_b)
  );

  adc_scan_fsm #(.NCH(NCH), .CH_W(CH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .mode(cfg_mode),
    .chan_mask(cfg_chan_mask), .single_ch(cfg_single_ch),
    .grpb_mask(cfg_grpb_mask), .trig_a(trig_a), .trig_b(trig_b),
    .cnv_busy(cnv_busy), .cnv_start(cnv_start), .cnv_ch(cnv_ch),
    .wr_en(wr_en), .wr_ch(wr_ch), .scan_done(scan_done),
    .done_grp(done_grp), .trig_missed(trig_missed), .seq_active(seq_active)
  );

  adc_result_bank #(.NCH(NCH), .CH_W(CH_W), .RES_W(RES_W), .DUAL_CH(DUAL_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(cnv_data), .shift_code(cfg_shift), .wr_val(wr_val),
    .dual_sel(dual_sel), .res_flat(res_flat), .res_dual(res_dual),
    .res_wr(res_wr), .res_ch(res_ch)
  );

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NCH     = 4,
  parameter int RES_W   = 12,
  parameter int DUAL_CH = 0,
  parameter int CH_W    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnv_start,
  input logic             cnv_busy,
  input logic             res_wr,
  input logic [CH_W-1:0]  res_ch,
  input logic [1:0]       mode,
  input logic [CH_W-1:0]  single_ch,
  input logic             scan_done,
  input logic             trig_missed,
  input logic             seq_active,
  input logic             wr_en,
  input logic [CH_W-1:0]  wr_ch,
  input logic [RES_W-1:0] wr_val,
  input logic [1:0]       shift_code,
  input logic             dual_sel
);

  AST_START_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> !cnv_busy); // R1
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start); // R1
  AST_SINGLE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr && mode == 2'd0) |-> (res_ch == single_ch)); // R2
  AST_DONE_WITH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> res_wr); // R3
  AST_MISSED_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_missed |-> $past(seq_active)); // R8
  AST_EIGHT_BIT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && shift_code == 2'd2) |-> (wr_val[RES_W-1 -: 4] == 4'd0)); // R9
  AST_DUAL_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ch == CH_W'(DUAL_CH)) |=> (dual_sel != $past(dual_sel))); // R10

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .NCH(NCH), .RES_W(RES_W), .DUAL_CH(DUAL_CH), .CH_W(CH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cnv_start(cnv_start), .cnv_busy(cnv_busy),
  .res_wr(res_wr), .res_ch(res_ch), .mode(cfg_mode), .single_ch(cfg_single_ch),
  .scan_done(scan_done), .trig_missed(trig_missed), .seq_active(seq_active),
  .wr_en(wr_en), .wr_ch(wr_ch), .wr_val(wr_val), .shift_code(cfg_shift),
  .dual_sel(dual_sel)
);

// File: tb/adc_scan_seq_test.sv
`timescale 1ns/1ps
module adc_scan_seq_test;

  localparam int NCH = 4;
  localparam int RW  = 12;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_en = 1'b0;
  logic [1:0] cfg_mode = 2'd0;
  logic [NCH-1:0] cfg_chan_mask = '0;
  logic [1:0] cfg_single_ch = '0;
  logic [NCH-1:0] cfg_grpb_mask = '0;
  logic [1:0] cfg_src_a = 2'd0, cfg_src_b = 2'd3, cfg_shift = 2'd0;
  logic sw_start = 1'b0, tmr_trig = 1'b0, ext_pin = 1'b0;
  logic cnv_start, cnv_busy;
  logic [1:0] cnv_ch;
  logic [RW-1:0] cnv_data;
  logic [NCH*RW-1:0] res_flat;
  logic [RW-1:0] res_dual;
  logic res_wr, scan_done, done_grp, trig_missed;
  logic [1:0] res_ch;

  always #10 clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .cfg_chan_mask(cfg_chan_mask), .cfg_single_ch(cfg_single_ch),
    .cfg_grpb_mask(cfg_grpb_mask), .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b),
    .cfg_shift(cfg_shift), .sw_start(sw_start), .tmr_trig(tmr_trig),
    .ext_pin(ext_pin), .cnv_start(cnv_start), .cnv_ch(cnv_ch),
    .cnv_busy(cnv_busy), .cnv_data(cnv_data), .res_flat(res_flat),
    .res_dual(res_dual), .res_wr(res_wr), .res_ch(res_ch),
    .scan_done(scan_done), .done_grp(done_grp), .trig_missed(trig_missed)
  );

  // converter stub
  int stub_cnt = 0;
  int stub_n = 0;
  logic [1:0] stub_ch = '0;
  initial begin cnv_busy = 1'b0; cnv_data = '0; end
  always @(posedge clk) begin
    if (cnv_start) begin
      cnv_busy <= 1'b1; stub_cnt <= LAT; stub_ch <= cnv_ch;
    end else if (cnv_busy) begin
      if (stub_cnt == 0) begin
        cnv_busy <= 1'b0;
        cnv_data <= RW'((int'(stub_ch) * 859 + stub_n * 487 + 165) % 4096);
        stub_n   <= stub_n + 1;
      end else stub_cnt <= stub_cnt - 1;
    end
  end

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nw = 0, nd = 0, nmiss = 0;
  int wlog [0:1023];
  int dgrp [0:255];
  int dat  [0:255];
  int exp_res [0:3];
  int exp_dual = 0;
  bit dtog = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic int reduce(input int v, input int code);
    if (code == 1) return v / 4;
    if (code == 2) return v / 16;
    return v;
  endfunction

  // monitor: model of the result registers, built from the stub output
  always @(negedge clk) begin
    if (rst_n) begin
      if (res_wr) begin
        int c, v;
        c = int'(res_ch);
        v = reduce(int'(cnv_data), int'(cfg_shift));
        wlog[nw] = c;
        nw++;
        chk(res_ch == stub_ch, "R1 stored channel", c, int'(stub_ch));
        if (c == 0) begin
          if (dtog) exp_dual = v; else exp_res[0] = v;
          dtog = !dtog;
        end else exp_res[c] = v;
        chk(int'(res_flat[c*RW +: RW]) == exp_res[c], "R9 R10 slot value",
            int'(res_flat[c*RW +: RW]), exp_res[c]);
        chk(int'(res_dual) == exp_dual, "R10 second register", int'(res_dual), exp_dual);
      end
      if (scan_done) begin
        dgrp[nd] = int'(done_grp);
        dat[nd]  = nw;
        nd++;
      end
      if (trig_missed) nmiss++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fire(input int src);
    @(negedge clk);
    if (src == 0) sw_start = 1'b1;
    else if (src == 1) tmr_trig = 1'b1;
    else ext_pin = 1'b1;
    @(negedge clk);
    sw_start = 1'b0; tmr_trig = 1'b0; ext_pin = 1'b0;
  endtask

  task automatic wait_done(input int target, input string req);
    int t;
    t = 0;
    while (nd < target && t < 3000) begin @(negedge clk); t++; end
    chk(nd >= target, req, nd, target);
    idle(2);
  endtask

  initial begin
    int w0, d0, m0, k;
    for (int i = 0; i < 4; i++) exp_res[i] = 0;
    idle(5);
    // R11 reset state
    chk(res_flat == '0, "R11 results zero", int'(res_flat[RW-1:0]), 0);
    chk(res_dual == '0, "R11 second register zero", int'(res_dual), 0);
    chk(!cnv_start && !res_wr && !scan_done && !trig_missed, "R11 strobes low",
        int'({cnv_start, res_wr, scan_done, trig_missed}), 0);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    cfg_en = 1'b1;

    // R2 R9 R10: single mode over every channel and shift code
    cfg_mode = 2'd0; cfg_src_a = 2'd0;
    for (int s = 0; s < 3; s++) begin
      for (int c = 0; c < 4; c++) begin
        cfg_shift = 2'(s); cfg_single_ch = 2'(c);
        w0 = nw; d0 = nd;
        fire(0);
        wait_done(d0 + 1, "R2 single done");
        chk(nw == w0 + 1, "R2 one conversion", nw - w0, 1);
        chk(wlog[nw-1] == c, "R2 chosen channel", wlog[nw-1], c);
      end
    end
    chk(int'(res_dual) == exp_dual, "R10 final second register", int'(res_dual), exp_dual);
    cfg_shift = 2'd3;
    cfg_single_ch = 2'd2; d0 = nd;
    fire(0);
    wait_done(d0 + 1, "R9 code 3");
    chk(int'(res_flat[2*RW +: RW]) == exp_res[2], "R9 code 3 raw", int'(res_flat[2*RW +: RW]), exp_res[2]);
    cfg_shift = 2'd0;

    // R3 R7 R12: one-pass over every mask, source rotating
    cfg_mode = 2'd1;
    for (int m = 0; m < 16; m++) begin
      cfg_chan_mask = 4'(m);
      cfg_src_a = 2'(m % 3);
      w0 = nw; d0 = nd;
      fire(m % 3);
      if (m == 0) begin
        idle(40);
        chk(nw == w0 && nd == d0, "R12 empty mask ignored", nw - w0, 0);
      end else begin
        wait_done(d0 + 1, "R7 source starts scan");
        chk(nw - w0 == $countones(4'(m)), "R3 one per enabled", nw - w0, $countones(4'(m)));
        k = w0;
        for (int b = 0; b < 4; b++)
          if (m[b]) begin
            chk(wlog[k] == b, "R3 ascending order", wlog[k], b);
            k++;
          end
        chk(dat[d0] == nw, "R3 done with last store", dat[d0], nw);
        idle(20);
        chk(nw == k, "R3 stops after pass", nw, k);
      end
    end

    // R7 source code 3 starts nothing
    cfg_chan_mask = 4'hF; cfg_src_a = 2'd3; w0 = nw;
    fire(0); fire(1); fire(2);
    idle(40);
    chk(nw == w0, "R7 no source", nw - w0, 0);

    // R12 disabled
    cfg_src_a = 2'd0; cfg_en = 1'b0; w0 = nw; m0 = nmiss;
    fire(0);
    idle(40);
    chk(nw == w0, "R12 disabled no start", nw - w0, 0);
    chk(nmiss == m0, "R12 disabled no missed", nmiss - m0, 0);
    cfg_en = 1'b1;

    // R8 trigger during a scan
    w0 = nw; d0 = nd; m0 = nmiss;
    fire(0);
    idle(4);
    fire(0);
    wait_done(d0 + 1, "R8 scan completes");
    idle(30);
    chk(nw - w0 == 4, "R8 extra trigger ignored", nw - w0, 4);
    chk(nmiss - m0 == 1, "R8 missed pulse", nmiss - m0, 1);

    // R4 continuous
    cfg_mode = 2'd2; cfg_chan_mask = 4'b1010;
    w0 = nw; d0 = nd;
    fire(0);
    wait_done(d0 + 2, "R4 repeats");
    cfg_en = 1'b0;
    k = nw;
    idle(60);
    chk(nw <= k + 1, "R4 stops after disable", nw, k + 1);
    chk(nw - w0 >= 4, "R4 two passes", nw - w0, 4);
    for (int i = w0; i < nw; i++)
      chk(wlog[i] == (((i - w0) % 2 == 0) ? 1 : 3), "R4 order", wlog[i], ((i - w0) % 2 == 0) ? 1 : 3);
    k = nw;
    idle(30);
    chk(nw == k, "R4 stays stopped", nw, k);
    cfg_en = 1'b1;

    // R5 R6 two groups: first {0,1} by timer, second {2,3} by pin
    cfg_mode = 2'd3; cfg_chan_mask = 4'hF; cfg_grpb_mask = 4'b1100;
    cfg_src_a = 2'd1; cfg_src_b = 2'd2;
    idle(2);
    w0 = nw; d0 = nd;
    @(negedge clk) begin tmr_trig = 1'b1; ext_pin = 1'b1; end
    @(negedge clk) begin tmr_trig = 1'b0; ext_pin = 1'b0; end
    wait_done(d0 + 2, "R6 both groups done");
    chk(nw - w0 == 4, "R6 four stores", nw - w0, 4);
    for (int i = 0; i < 4; i++) chk(wlog[w0+i] == i, "R6 first group first", wlog[w0+i], i);
    chk(dgrp[d0] == 0 && dat[d0] == w0 + 2, "R6 first group done", dgrp[d0], 0);
    chk(dgrp[d0+1] == 1 && dat[d0+1] == w0 + 4, "R6 second group done", dgrp[d0+1], 1);
    w0 = nw; d0 = nd;
    fire(2);
    wait_done(d0 + 1, "R5 second group alone");
    chk(nw - w0 == 2 && wlog[w0] == 2 && wlog[w0+1] == 3, "R5 second group set", wlog[w0], 2);
    chk(dgrp[d0] == 1, "R5 second group tag", dgrp[d0], 1);
    w0 = nw; d0 = nd;
    fire(1);
    wait_done(d0 + 1, "R5 first group alone");
    chk(nw - w0 == 2 && wlog[w0] == 0 && wlog[w0+1] == 1, "R5 first group set", wlog[w0], 0);
    chk(dgrp[d0] == 0, "R5 first group tag", dgrp[d0], 0);

    summary();
    $finish;
  end

endmodule